// File: doc/BRIEF.md
# Two-Group Exclusive Bus Selector

The block picks one of six data words and loads it into a registered output bus. Each word has its own enable line, and the six enables are split into two fixed groups of three. Inside a group the enables must be zero-or-one-hot. Because of that rule, the group's value is built as an AND-OR network, with no priority chain: each word is masked by its replicated enable and the masked words are ORed together.

The lower group (enables 0 to 2) has priority over the upper group (enables 3 to 5). The upper group is used only when the whole lower group is idle. When no enable is active, the output register keeps its value.

A checker bound into the design stops the simulation when two enables of the same group are active in one cycle. The block is meant to sit where several producers share one result bus and a controller already guarantees exclusivity inside each set of producers.

Top module: `grp_excl_sel`

## Requirements
- R1: The active-high reset `rst` clears `q` to zero immediately, without waiting for a clock edge, and `q` stays zero while `rst` is high.
- R2: When exactly one enable of the lower group (`en[0]`, `en[1]` or `en[2]`) is high at a rising edge, `q` shows the matching data word after that edge. Word i sits at `din[i*DATA_W +: DATA_W]`.
- R3: When the lower group is all zero and exactly one enable of the upper group (`en[3]`, `en[4]` or `en[5]`) is high at a rising edge, `q` shows the matching word after that edge.
- R4: When the lower group has an active enable, the state of the upper group has no effect on `q`.
- R5: When all six enables are low at a rising edge, `q` keeps its previous value whatever `din` carries.
- R6: The value of a group is the bitwise OR of its three words, each ANDed with its own enable replicated over the full width. Every bit position of the selected word reaches `q`.
- R7: In simulation, two or more active enables inside one group in the same cycle (outside reset) end the run with a fatal error. An all-zero group is legal.
- R8: `q` changes only at a rising clock edge (apart from reset). New enables or data driven between edges do not show at `q` until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset of the output register |
| en | input | 6 | Per-word enables; bits 0-2 form the lower (priority) group, bits 3-5 the upper group |
| din | input | 6*DATA_W | Six data words, word i at bits [i*DATA_W +: DATA_W] |
| q | output | DATA_W | Registered selected word |

## Verification
The bench builds the block with its default 64-bit width, so all 384 input bits and the whole output word are live. Random full-width words reach every lane of the AND-OR network and catch a word offset or a dropped bit lane. Random patterns across both groups combine every legal lower-group state with every legal upper-group state, which brings the priority and hold paths within reach. Directed steps add a mid-cycle asynchronous reset and inputs changed between edges.

// File: rtl/gxs_pkg.sv
package gxs_pkg;
  localparam int GRP_SIZE = 3;
  localparam int NUM_GRP  = 2;
  localparam int NUM_SRC  = GRP_SIZE * NUM_GRP;

  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_LOWER = 2'd1,
    SRC_UPPER = 2'd2
  } src_e;

  // Lower group always wins; upper group only when lower is idle.
  function automatic src_e pick_src(input logic lower_hit, input logic upper_hit);
    if (lower_hit)      return SRC_LOWER;
    else if (upper_hit) return SRC_UPPER;
    else                return SRC_HOLD;
  endfunction
endpackage

// File: rtl/gxs_grp_mux.sv
module gxs_grp_mux #(
  parameter int DATA_W = 64,
  parameter int N      = 3
) (
  input  logic [N*DATA_W-1:0] words,
  input  logic [N-1:0]        en,
  output logic [DATA_W-1:0]   val,
  output logic                hit
);
  logic [DATA_W-1:0] gated [N];

  // Mask each word with its replicated enable.
  for (genvar i = 0; i < N; i++) begin : g_gate
    assign gated[i] = words[i*DATA_W +: DATA_W] & {DATA_W{en[i]}};
  end

  // OR the masked words; valid only under the zero-one-hot rule.
  always_comb begin
    val = '0;
    for (int i = 0; i < N; i++) val = val | gated[i];
  end

  assign hit = |en;
endmodule

// File: rtl/gxs_arb.sv
module gxs_arb
  import gxs_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              lower_hit,
  input  logic [DATA_W-1:0] lower_val,
  input  logic              upper_hit,
  input  logic [DATA_W-1:0] upper_val,
  output logic              load,
  output logic [DATA_W-1:0] nxt
);
  src_e src;

  assign src = pick_src(lower_hit, upper_hit);

  always_comb begin
    unique case (src)
      SRC_LOWER: nxt = lower_val;
      SRC_UPPER: nxt = upper_val;
      default:   nxt = '0;
    endcase
  end

  assign load = (src != SRC_HOLD);
endmodule

// File: rtl/gxs_oreg.sv
module gxs_oreg #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/grp_excl_sel.sv
module grp_excl_sel
  import gxs_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_SRC-1:0]          en,
  input  logic [NUM_SRC*DATA_W-1:0]   din,
  output logic [DATA_W-1:0]           q
);
  localparam int GRP_BITS = GRP_SIZE * DATA_W;

  logic [DATA_W-1:0] grp_val [NUM_GRP];
  logic [NUM_GRP-1:0] grp_hit;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    gxs_grp_mux #(.DATA_W(DATA_W), .N(GRP_SIZE)) u_mux (
      .words (din[g*GRP_BITS +: GRP_BITS]),
      .en    (en[g*GRP_SIZE +: GRP_SIZE]),
      .val   (grp_val[g]),
      .hit   (grp_hit[g])
    );
  end

  // Named internal events for the checker.
  logic              lower_hit;
  logic              upper_hit;
  logic              load;
  logic [DATA_W-1:0] nxt;

  assign lower_hit = grp_hit[0];
  assign upper_hit = grp_hit[1];

  gxs_arb #(.DATA_W(DATA_W)) u_arb (
    .lower_hit (lower_hit),
    .lower_val (grp_val[0]),
    .upper_hit (upper_hit),
    .upper_val (grp_val[1]),
    .load      (load),
    .nxt       (nxt)
  );

  gxs_oreg #(.DATA_W(DATA_W)) u_oreg (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .d    (nxt),
    .q    (q)
  );
endmodule

// File: rtl/gxs_checker.sv
module gxs_checker #(
  parameter int DATA_W = 64
) (
  input logic                  clk,
  input logic                  rst,
  input logic [5:0]            en,
  input logic [6*DATA_W-1:0]   din,
  input logic [DATA_W-1:0]     q,
  input logic                  lower_hit,
  input logic                  load
);
  // R7
  lower_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en[2:0]))
    else $fatal(1, "R7 lower group not zero-one-hot: %b", en[2:0]);

  // R7
  upper_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en[5:3]))
    else $fatal(1, "R7 upper group not zero-one-hot: %b", en[5:3]);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en == 6'd0) |=> $stable(q));

  // R4
  lower_wins_chk: assert property (@(posedge clk) disable iff (rst)
    en[1] |=> (q == $past(din[DATA_W +: DATA_W])));

  // R3
  upper_alone_chk: assert property (@(posedge clk) disable iff (rst)
    ((en[2:0] == 3'd0) && en[5]) |=> (q == $past(din[5*DATA_W +: DATA_W])));

  // R8
  noload_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !lower_hit) |=> $stable(q));

  // R1
  always @(posedge clk) begin
    if (rst) begin
      reset_clear_chk: assert (q == '0);
    end
  end
endmodule

bind grp_excl_sel gxs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .din       (din),
  .q         (q),
  .lower_hit (lower_hit),
  .load      (load)
);

// File: tb/grp_excl_sel_tb.sv
module grp_excl_sel_tb;
  localparam int W = 64;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [5:0]       en  = '0;
  logic [6*W-1:0]   din = '0;
  logic [W-1:0]     q;
  logic [W-1:0]     expq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  grp_excl_sel #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .en(en), .din(din), .q(q)
  );

  // Reference: scan words in order, first active group decides.
  function automatic logic [W-1:0] ref_model(input logic [5:0] e,
                                             input logic [6*W-1:0] d,
                                             input logic [W-1:0] prev);
    logic [W-1:0] lo = '0, hi = '0;
    for (int i = 0; i < 6; i++) begin
      if (e[i]) begin
        if (i < 3) lo = lo | d[i*W +: W];
        else       hi = hi | d[i*W +: W];
      end
    end
    if (e[2:0] != 0) return lo;
    if (e[5:3] != 0) return hi;
    return prev;
  endfunction

  function automatic logic [W-1:0] rnd_word();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [2:0] rnd_grp();
    int k = $urandom_range(0, 3);
    return (k == 0) ? 3'b000 : 3'(1 << (k - 1));
  endfunction

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: q=%h expected %h", req, act, exp);
    end
  endtask

  // Drive at negedge, clock once, sample at the following negedge.
  task automatic step(input string req, input logic [5:0] e,
                      input logic [6*W-1:0] d);
    en   = e;
    din  = d;
    expq = ref_model(e, d, expq);
    @(posedge clk);
    @(negedge clk);
    check(req, q, expq);
  endtask

  function automatic logic [6*W-1:0] rnd_din();
    logic [6*W-1:0] d;
    for (int i = 0; i < 6; i++) d[i*W +: W] = rnd_word();
    return d;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    expq = '0;
    repeat (2) @(negedge clk);
    // R1 reset value
    check("R1", q, '0);
    rst = 1'b0;
    @(negedge clk);

    // R2 / R6: each lower enable alone, full-width words
    for (int i = 0; i < 3; i++) step("R2", 6'(1 << i), rnd_din());
    // R3: each upper enable alone
    for (int i = 3; i < 6; i++) step("R3", 6'(1 << i), rnd_din());
    // R6: all-ones and alternating patterns through one lane
    step("R6", 6'b000100, {6{64'hFFFF_FFFF_FFFF_FFFF}});
    step("R6", 6'b010000, {6{64'hA5A5_5A5A_0F0F_F0F0}});
    // R4: both groups active, lower wins
    step("R4", 6'b100001, rnd_din());
    step("R4", 6'b001010, rnd_din());
    // R5: idle hold with changing data
    step("R5", 6'b000000, rnd_din());
    step("R5", 6'b000000, rnd_din());

    // R8: new inputs between edges must not reach q before the edge
    en  = 6'b000010;
    din = rnd_din();
    #1;
    check("R8", q, expq);
    expq = ref_model(en, din, expq);
    @(posedge clk);
    @(negedge clk);
    check("R8", q, expq);

    // R1: asynchronous clear in the middle of a cycle
    #1 rst = 1'b1;
    #1 check("R1", q, '0);
    expq = '0;
    @(negedge clk);
    check("R1", q, '0);
    rst = 1'b0;
    en  = '0;
    @(negedge clk);

    // Random legal patterns across both groups (R2..R6)
    for (int n = 0; n < 400; n++) begin
      logic [5:0] e;
      e = {rnd_grp(), rnd_grp()};
      if (e[2:0] != 0)      step("R2", e, rnd_din());
      else if (e[5:3] != 0) step("R3", e, rnd_din());
      else                  step("R5", e, rnd_din());
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: q=%h expected %h", q, expq);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule